// File: doc/BRIEF.md
# Register-mapped I2C master controller

This block is a single-bus I2C master that software drives by polling. A byte-wide host port reaches a small register file that holds the bus timing, two byte counts, a command and a buffer of bytes. The host programs everything else first and writes the command register last. That write starts a complete buffered transaction on the bus. The transaction ends with a STOP, and software sees the result in the status register.

Several transfer shapes come from one register set:

- **Send byte/block:** a plain write.
- **Receive byte/block:** a read with no address prefix.
- **Write byte/block:** a write whose first buffer bytes act as a device-internal address.
- **Read byte/block:** a combined transaction. The address bytes are written, a repeated START follows, and then the data bytes are read back into the buffer.

SCL and SDA are open-drain. The block only ever pulls each line low, through an output-enable, and it reads SDA back through its own input.

Top module: `i2cm_top`

## Requirements
- R1: After reset the host reads the following:
  - capability register (offset 0x00) is 0xA0: bit 7 = 1 means block read is supported, bits [6:5] = 01 means 72-byte transactions.
  - half-cycle register (0x04) is 0x02.
  - hold register (0x05), command register (0x06) and status register (0x09) are 0x00.
  - every buffer byte (0x0A upward) is 0x00.
- R2: A write to the command register (0x06) while idle starts a transaction. Command bit 0 is the direction (0 write, 1 read) and bits [7:1] are the 7-bit target address. The first byte on the bus is {address, 0}, or {address, 1} for a read with zero address bytes. Every transaction ends with the done bit set.
- R3: One SCL half period lasts 4 x the half-cycle register clock cycles, and a value of 0 acts as 1. A transaction occupies exactly 2 + 18 x (bytes on the bus, address bytes included) + 3 x (repeated STARTs) + 3 half periods. Status bit 6 (busy) is high for exactly that many cycles after the command write.
- R4: Each SDA output-enable change made while SCL is held low occurs exactly min(hold, 4 x half - 2) + 1 clock cycles after SCL was pulled low.
- R5: In a write, the block sends the address-count (0x08) plus data-count (0x07) bytes. They are taken from the buffer in order, starting at offset 0x0A.
- R6: A read with a non-zero address count is a combined transaction:
  - the address-count bytes are sent from the buffer in a write phase;
  - a repeated START and {address, 1} follow;
  - data-count bytes are then read and stored in the buffer starting at 0x0A.
- R7: While reading, the master ACKs every byte except the last, which it NACKs.
- R8: A NACK on an address byte or a write byte ends the transfer with a STOP, and status reads 0x11. A transaction with no NACK ends with status 0x01.
- R9: While busy, a host write to any register other than control is ignored. This includes a new command and writes to the buffer.
- R10: Any write to the control register (0x01) returns every register and the whole buffer to the reset values of R1.
- R11: While no transaction is running, both SCL and SDA are released (output-enables low).
- R12: Starting a new command clears the done and NACK bits, and done is never set while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe, one byte per cycle |
| host_addr | input | 7 | Register byte offset for both read and write |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register value at host_addr, combinational |
| scl_oe | output | 1 | Pulls SCL low when high |
| sda_oe | output | 1 | Pulls SDA low when high |
| sda_in | input | 1 | Sampled level of the SDA line |

## Verification
The hardest situations to reach from the ports depend on the target, not on the master:
- a NACK that arrives on a middle write byte, after earlier bytes were acknowledged;
- the exact point where a combined read turns around with a repeated START and the target starts driving data.

The bench gets there with a behavioural open-drain target on the wired lines. Its acknowledge cut-off and its read-back bytes are programmable, so each case is staged deliberately. The target logs every byte and every master acknowledge. A cycle-count model of the transaction checks the busy bit on every clock, so a byte sent too many or too few shows up as a miscompare.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    localparam int AW = 7;

    localparam logic [AW-1:0] OFF_CAP  = 7'h00;
    localparam logic [AW-1:0] OFF_CTRL = 7'h01;
    localparam logic [AW-1:0] OFF_HALF = 7'h04;
    localparam logic [AW-1:0] OFF_HOLD = 7'h05;
    localparam logic [AW-1:0] OFF_CMD  = 7'h06;
    localparam logic [AW-1:0] OFF_NDAT = 7'h07;
    localparam logic [AW-1:0] OFF_NADR = 7'h08;
    localparam logic [AW-1:0] OFF_STAT = 7'h09;
    localparam logic [AW-1:0] OFF_BUF  = 7'h0A;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_START2, S_BITLO, S_BITHI,
        S_RSLO, S_STOPLO, S_STOPHI, S_STOPEND
    } st_e;

    typedef enum logic [1:0] {K_AW, K_TX, K_AR, K_RX} kind_e;
endpackage

// File: rtl/i2cm_timer.sv
module i2cm_timer #(
    parameter int CW = 10
) (
    input  logic [7:0]    half,
    input  logic [7:0]    hold,
    input  logic [CW-1:0] cnt,
    output logic          pend,
    output logic          hold_hit
);
    logic [CW-1:0] per;
    logic [CW-1:0] hmax;
    logic [CW-1:0] heff;

    always_comb begin
        per      = (half == 8'd0) ? CW'(4) : CW'({half, 2'b00});
        hmax     = per - CW'(2);
        heff     = (CW'(hold) > hmax) ? hmax : CW'(hold);
        pend     = (cnt == per - CW'(1));
        hold_hit = (cnt == heff);
    end
endmodule

// File: rtl/i2cm_rdmux.sv
module i2cm_rdmux
    import i2cm_pkg::*;
#(
    parameter int DEPTH = 75
) (
    input  logic [AW-1:0]    addr,
    input  logic [7:0]       cap,
    input  logic [7:0]       half,
    input  logic [7:0]       hold,
    input  logic [7:0]       cmd,
    input  logic [7:0]       ndata,
    input  logic [7:0]       naddr,
    input  logic [7:0]       status,
    input  logic [DEPTH*8-1:0] mem,
    output logic [7:0]       rdata
);
    always_comb begin
        rdata = 8'h00;
        case (addr)
            OFF_CAP:  rdata = cap;
            OFF_HALF: rdata = half;
            OFF_HOLD: rdata = hold;
            OFF_CMD:  rdata = cmd;
            OFF_NDAT: rdata = ndata;
            OFF_NADR: rdata = naddr;
            OFF_STAT: rdata = status;
            default: begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (int'(addr) == int'(OFF_BUF) + i) rdata = mem[i*8 +: 8];
                end
            end
        endcase
    end
endmodule

// File: rtl/i2cm_top.sv
module i2cm_top
    import i2cm_pkg::*;
#(
    parameter int         BUF_DEPTH = 75,
    parameter logic [7:0] HALF_RST  = 8'd2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    output logic          scl_oe,
    output logic          sda_oe,
    input  logic          sda_in
);
    localparam int CW = 10;
    localparam int IW = 9;
    localparam int BI = $clog2(BUF_DEPTH);
    localparam logic [IW-1:0] DEPTH_L = IW'(BUF_DEPTH);
    localparam logic [AW-1:0] OFF_END = AW'(int'(OFF_BUF) + BUF_DEPTH);
    localparam logic [1:0]    LEN_CODE = (BUF_DEPTH >= 72) ? 2'b01 : 2'b00;
    localparam logic [7:0]    CAP = {1'b1, LEN_CODE, 5'b00000};

    typedef struct packed {
        st_e                         st;
        kind_e                       kind;
        logic [CW-1:0]               cnt;
        logic [3:0]                  bitn;
        logic [7:0]                  sh;
        logic [IW-1:0]               idx;
        logic                        scl;
        logic                        sda;
        logic [7:0]                  half;
        logic [7:0]                  hold;
        logic [7:0]                  cmd;
        logic [7:0]                  ndata;
        logic [7:0]                  naddr;
        logic                        done;
        logic                        nack;
        logic [BUF_DEPTH-1:0][7:0]   mem;
    } st_t;

    function automatic st_t rst_val();
        st_t r;
        r      = '0;
        r.st   = S_IDLE;
        r.kind = K_AW;
        r.half = HALF_RST;
        return r;
    endfunction

    function automatic logic [7:0] pick(input logic [BUF_DEPTH-1:0][7:0] m,
                                        input logic [IW-1:0] i);
        return (i < DEPTH_L) ? m[i[BI-1:0]] : 8'h00;
    endfunction

    st_t st_d, st_q;
    logic          pend, hold_hit, drv, busy_w;
    logic [IW-1:0] txtot, idx_n;
    logic [7:0]    nxt;
    logic [AW-1:0] boff;

    i2cm_timer #(.CW(CW)) u_tmr (
        .half(st_q.half), .hold(st_q.hold), .cnt(st_q.cnt),
        .pend(pend), .hold_hit(hold_hit)
    );

    assign busy_w = (st_q.st != S_IDLE);

    always_comb begin
        st_d  = st_q;
        txtot = {1'b0, st_q.naddr} + (st_q.cmd[0] ? IW'(0) : {1'b0, st_q.ndata});
        idx_n = st_q.idx + IW'(1);
        nxt   = pick(st_q.mem, idx_n);
        boff  = host_addr - OFF_BUF;
        if (st_q.bitn[3]) drv = (st_q.kind == K_RX) && (idx_n < {1'b0, st_q.ndata});
        else              drv = (st_q.kind == K_RX) ? 1'b0 : ~st_q.sh[7];
        if (busy_w) st_d.cnt = pend ? '0 : st_q.cnt + CW'(1);

        case (st_q.st)
            S_START:   if (pend) begin st_d.sda = 1'b1; st_d.st = S_START2; end
            S_START2:  if (pend) begin st_d.scl = 1'b1; st_d.st = S_BITLO; end
            S_BITLO: begin
                if (hold_hit) st_d.sda = drv;
                if (pend) begin st_d.scl = 1'b0; st_d.st = S_BITHI; end
            end
            S_BITHI: if (pend) begin
                st_d.scl = 1'b1;
                st_d.st  = S_BITLO;
                if (!st_q.bitn[3]) begin
                    st_d.bitn = st_q.bitn + 4'd1;
                    st_d.sh   = {st_q.sh[6:0], (st_q.kind == K_RX) ? sda_in : 1'b0};
                end else begin
                    st_d.bitn = '0;
                    case (st_q.kind)
                        K_AW: begin
                            if (sda_in) begin st_d.nack = 1'b1; st_d.st = S_STOPLO; end
                            else if (txtot != '0) begin
                                st_d.kind = K_TX; st_d.idx = '0; st_d.sh = pick(st_q.mem, '0);
                            end else st_d.st = S_STOPLO;
                        end
                        K_TX: begin
                            if (sda_in) begin st_d.nack = 1'b1; st_d.st = S_STOPLO; end
                            else if (idx_n < txtot) begin st_d.idx = idx_n; st_d.sh = nxt; end
                            else if (st_q.cmd[0]) begin
                                st_d.st = S_RSLO; st_d.kind = K_AR; st_d.sh = {st_q.cmd[7:1], 1'b1};
                            end else st_d.st = S_STOPLO;
                        end
                        K_AR: begin
                            if (sda_in) begin st_d.nack = 1'b1; st_d.st = S_STOPLO; end
                            else if (st_q.ndata == 8'd0) st_d.st = S_STOPLO;
                            else begin st_d.kind = K_RX; st_d.idx = '0; end
                        end
                        default: begin
                            if (st_q.idx < DEPTH_L) st_d.mem[st_q.idx[BI-1:0]] = st_q.sh;
                            if (idx_n < {1'b0, st_q.ndata}) st_d.idx = idx_n;
                            else st_d.st = S_STOPLO;
                        end
                    endcase
                end
            end
            S_RSLO: begin
                if (hold_hit) st_d.sda = 1'b0;
                if (pend) begin st_d.scl = 1'b0; st_d.st = S_START; end
            end
            S_STOPLO: begin
                if (hold_hit) st_d.sda = 1'b1;
                if (pend) begin st_d.scl = 1'b0; st_d.st = S_STOPHI; end
            end
            S_STOPHI:  if (pend) begin st_d.sda = 1'b0; st_d.st = S_STOPEND; end
            S_STOPEND: if (pend) begin st_d.st = S_IDLE; st_d.done = 1'b1; end
            default: ;
        endcase

        if (host_we) begin
            if (host_addr == OFF_CTRL) st_d = rst_val();
            else if (!busy_w) begin
                case (host_addr)
                    OFF_HALF: st_d.half  = host_wdata;
                    OFF_HOLD: st_d.hold  = host_wdata;
                    OFF_NDAT: st_d.ndata = host_wdata;
                    OFF_NADR: st_d.naddr = host_wdata;
                    OFF_CMD: begin
                        st_d.cmd  = host_wdata;
                        st_d.done = 1'b0;
                        st_d.nack = 1'b0;
                        st_d.st   = S_START;
                        st_d.cnt  = '0;
                        st_d.bitn = '0;
                        st_d.idx  = '0;
                        if (host_wdata[0] && st_q.naddr == 8'd0) begin
                            st_d.kind = K_AR; st_d.sh = host_wdata;
                        end else begin
                            st_d.kind = K_AW; st_d.sh = {host_wdata[7:1], 1'b0};
                        end
                    end
                    default: if (host_addr >= OFF_BUF && host_addr < OFF_END)
                                 st_d.mem[boff[BI-1:0]] = host_wdata;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= rst_val();
        else        st_q <= st_d;
    end

    assign scl_oe = st_q.scl;
    assign sda_oe = st_q.sda;

    i2cm_rdmux #(.DEPTH(BUF_DEPTH)) u_rd (
        .addr(host_addr), .cap(CAP), .half(st_q.half), .hold(st_q.hold),
        .cmd(st_q.cmd), .ndata(st_q.ndata), .naddr(st_q.naddr),
        .status({1'b0, busy_w, 1'b0, st_q.nack, 3'b000, st_q.done}),
        .mem(st_q.mem), .rdata(host_rdata)
    );
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_we,
    input logic [6:0] host_addr,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       busy,
    input logic       done,
    input logic [7:0] cmd
);
    assert_idle_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

    assert_done_not_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_cmd_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_we && host_addr == 7'h06) |=> $stable(cmd));

    assert_end_sets_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(host_we && host_addr == 7'h01)) |-> done);
endmodule

bind i2cm_top i2cm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy_w),
    .done(st_q.done), .cmd(st_q.cmd)
);

// File: tb/sim_i2cm_top.sv
module sim_i2cm_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       we = 1'b0;
    logic [6:0] addr = 7'h09;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       scl_oe, sda_oe;
    logic       s_oe = 1'b0;
    wire        scl_w = ~scl_oe;
    wire        sda_w = ~(sda_oe | s_oe);

    i2cm_top u0 (
        .clk(clk), .rst_n(rst_n), .host_we(we), .host_addr(addr),
        .host_wdata(wdata), .host_rdata(rdata),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_w)
    );

    int nvec = 0, nbad = 0;
    bit ended = 0;

    task automatic chk(input string r, input int act, input int exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // ---------------- behavioural open-drain target ----------------
    logic [7:0] log_q[$];
    bit         mack_q[$];
    logic [7:0] rmem[0:3];
    int   rptr = 0, bc = 0, nack_at = 1000;
    bit   active = 0, in_addr = 0, matched = 0, rdm = 0;
    logic [7:0] sh = 0, tx = 0;

    always @(negedge sda_w) if (scl_w === 1'b1) begin
        active = 1; bc = 0; in_addr = 1; matched = 0; rptr = 0; s_oe = 0;
    end
    always @(posedge sda_w) if (scl_w === 1'b1) begin
        active = 0; s_oe = 0;
    end
    always @(posedge scl_w) if (active) begin
        if (bc < 8) begin
            if (!(rdm && !in_addr)) sh = {sh[6:0], sda_w};
        end else if (bc == 8 && rdm && !in_addr) mack_q.push_back(!sda_w);
        bc++;
    end
    always @(negedge scl_w) if (active) begin
        if (bc == 8) begin
            if (in_addr) begin matched = (sh[7:1] == 7'h50); rdm = sh[0]; s_oe = matched; end
            else if (!rdm) begin log_q.push_back(sh); s_oe = matched && (log_q.size() <= nack_at); end
            else s_oe = 0;
        end else if (bc == 9) begin
            bc = 0; s_oe = 0;
            if (rdm && matched && (in_addr || mack_q[$])) begin
                tx = rmem[rptr]; rptr++; s_oe = ~tx[7];
            end
            in_addr = 0;
        end else if (bc >= 1 && bc <= 7 && rdm && !in_addr && matched) s_oe = ~tx[7-bc];
    end

    // ---------------- SDA hold monitor (R4) ----------------
    int  hold_exp = 1, lo = 0;
    bit  pscl = 0, psda = 0;
    always @(negedge clk) begin
        if (scl_oe) begin
            lo = pscl ? lo + 1 : 0;
            if (pscl && sda_oe !== psda) chk("R4 sda delay", lo, hold_exp);
        end
        pscl = scl_oe; psda = sda_oe;
    end

    // ---------------- host tasks ----------------
    task automatic wr(input logic [6:0] a, input logic [7:0] v);
        @(negedge clk); we = 1; addr = a; wdata = v;
        @(negedge clk); we = 0; addr = 7'h09;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; #1; v = rdata; addr = 7'h09;
    endtask

    task automatic setup(input int half, input int hold, input int na, input int nd);
        int h = (half == 0) ? 4 : 4 * half;
        wr(7'h04, 8'(half)); wr(7'h05, 8'(hold));
        wr(7'h08, 8'(na));   wr(7'h07, 8'(nd));
        hold_exp = ((hold < h - 2) ? hold : h - 2) + 1;
        log_q.delete(); mack_q.delete();
    endtask

    // Cycle model of R3: busy high for exactly phases*H cycles after command.
    task automatic run(input logic [7:0] c, input int cyc);
        wr(7'h06, c);
        for (int j = 0; j < cyc + 3; j++) begin
            #1;
            if (j == 0) chk("R12 done/nack cleared at start", rdata & 8'h11, 0);
            chk("R3 busy cycle model", rdata[6], (j < cyc) ? 1 : 0);
            @(negedge clk);
        end
    endtask

    logic [7:0] v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 / R11 reset state
        rd(7'h00, v); chk("R1 capability", v, 8'hA0);
        rd(7'h04, v); chk("R1 half default", v, 8'h02);
        rd(7'h05, v); chk("R1 hold default", v, 8'h00);
        rd(7'h06, v); chk("R1 cmd default", v, 8'h00);
        rd(7'h09, v); chk("R1 status default", v, 8'h00);
        rd(7'h0A, v); chk("R1 buffer default", v, 8'h00);
        chk("R11 lines released", {scl_oe, sda_oe}, 0);

        // R5 write block with 2 address prefix bytes: 6 bytes, H=4
        setup(1, 1, 2, 3);
        wr(7'h0A, 8'hA1); wr(7'h0B, 8'hA2); wr(7'h0C, 8'hD1); wr(7'h0D, 8'hD2); wr(7'h0E, 8'hD3);
        run(8'hA0, (2 + 18*6 + 3) * 4);
        chk("R5 byte count", log_q.size(), 5);
        if (log_q.size() == 5) begin
            chk("R5 byte0", log_q[0], 8'hA1); chk("R5 byte2", log_q[2], 8'hD1);
            chk("R5 byte4", log_q[4], 8'hD3);
        end
        rd(7'h09, v); chk("R8 status ok", v, 8'h01);
        chk("R11 idle release", {scl_oe, sda_oe}, 0);

        // R6 / R7 combined read: 1 address byte, 3 data bytes, H=8
        setup(2, 2, 1, 3);
        wr(7'h0A, 8'h33);
        rmem[0] = 8'h5A; rmem[1] = 8'hC3; rmem[2] = 8'h0F; rmem[3] = 8'hFF;
        run(8'hA1, (2 + 18 + 18 + 3 + 18 + 54 + 3) * 8);
        chk("R6 address prefix count", log_q.size(), 1);
        if (log_q.size() == 1) chk("R6 address prefix byte", log_q[0], 8'h33);
        rd(7'h0A, v); chk("R6 read byte0", v, 8'h5A);
        rd(7'h0B, v); chk("R6 read byte1", v, 8'hC3);
        rd(7'h0C, v); chk("R6 read byte2", v, 8'h0F);
        chk("R7 ack count", mack_q.size(), 3);
        if (mack_q.size() == 3) begin
            chk("R7 ack first", mack_q[0], 1); chk("R7 ack middle", mack_q[1], 1);
            chk("R7 nack last", mack_q[2], 0);
        end
        rd(7'h09, v); chk("R8 status ok after read", v, 8'h01);

        // R2 receive byte (no prefix, read address direct), hold 0
        setup(1, 0, 0, 1);
        rmem[0] = 8'h96;
        run(8'hA1, (2 + 18 + 18 + 3) * 4);
        rd(7'h0A, v); chk("R2 receive byte", v, 8'h96);
        chk("R2 no write phase", log_q.size(), 0);
        chk("R7 single byte nack", (mack_q.size() == 1) ? mack_q[0] : 9, 0);

        // R8 address NACK
        setup(1, 1, 0, 2);
        run(8'h42, (2 + 18 + 3) * 4);
        rd(7'h09, v); chk("R8 address nack status", v, 8'h11);
        chk("R8 nothing written", log_q.size(), 0);

        // R8 data NACK on second byte
        setup(1, 1, 0, 3);
        nack_at = 1;
        run(8'hA0, (2 + 18*3 + 3) * 4);
        nack_at = 1000;
        rd(7'h09, v); chk("R8 data nack status", v, 8'h11);
        chk("R8 stopped after nacked byte", log_q.size(), 2);

        // R3/R4 half 0 acts as 1, hold clamped to H-2
        setup(0, 9, 0, 1);
        wr(7'h0A, 8'h55);
        run(8'hA0, (2 + 36 + 3) * 4);
        chk("R3 half zero transfer", (log_q.size() == 1) ? log_q[0] : 0, 8'h55);

        // R9 writes ignored while busy
        setup(1, 1, 0, 1);
        wr(7'h0A, 8'h77);
        wr(7'h06, 8'hA0);
        wr(7'h06, 8'h00); wr(7'h04, 8'h07); wr(7'h0A, 8'hEE);
        for (int k = 0; k < 400; k++) begin
            rd(7'h09, v);
            if (!v[6]) break;
        end
        rd(7'h06, v); chk("R9 cmd kept", v, 8'hA0);
        rd(7'h04, v); chk("R9 half kept", v, 8'h01);
        rd(7'h0A, v); chk("R9 buffer kept", v, 8'h77);
        chk("R9 sent original byte", (log_q.size() == 1) ? log_q[0] : 0, 8'h77);

        // R10 control reset
        wr(7'h01, 8'h5C);
        rd(7'h04, v); chk("R10 half reset", v, 8'h02);
        rd(7'h05, v); chk("R10 hold reset", v, 8'h00);
        rd(7'h06, v); chk("R10 cmd reset", v, 8'h00);
        rd(7'h07, v); chk("R10 count reset", v, 8'h00);
        rd(7'h09, v); chk("R10 status reset", v, 8'h00);
        rd(7'h0A, v); chk("R10 buffer reset", v, 8'h00);

        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            nvec++; nbad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule